// File: doc/BRIEF.md
# Parallel Min-Sum Trellis Check Node Processor

This block is the parity-side processor of a message-passing decoder for low-density parity-check codes. A whole check of degree four is handed over in one cycle: four signed log-likelihood messages arrive together with a valid strobe. Two cycles later the block returns four extrinsic messages, one per edge. The message for edge k is built only from the other three inputs.

Inside, each message is turned into sign and magnitude. A forward chain of running combinations and a backward chain are then formed across the edges. Output k merges the forward value that stops just before edge k with the backward value that starts just after it. The pairwise combination is min-sum: the signs are XORed and the smaller magnitude is kept. A new group may enter on every cycle. A decoder places several of these side by side and streams the checks of an iteration through them.

Top module: `cnp_trellis_top`

## Requirements
- R1: `valid_out` equals `valid_in` delayed by exactly two clock cycles. The output group belonging to an input group appears in that same cycle.
- R2: Input groups may arrive on consecutive cycles without gaps, and each of them produces its own correct output group.
- R3: The sign of output k (1 = negative, two's complement) is the XOR of the signs of every input except input k. A zero input counts as positive.
- R4: The magnitude of output k is the smallest magnitude among every input except input k.
- R5: An input holding the most negative code (-32 at the default width) is treated as -31. No magnitude overflows.
- R6: An output never takes the most negative code. When the selected magnitude is zero, the output is 0 whatever the sign parity.
- R7: While `rst_n` is low, and until a valid group has passed through, `valid_out` is 0 and `llr_out` is all zeros.
- R8: Edge k occupies bits [k*W +: W] of both `llr_in` and `llr_out`, written as a W-bit two's-complement value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Qualifies `llr_in` in this cycle |
| llr_in | input | DEG*W | Variable-to-check messages, edge k at [k*W +: W] |
| valid_out | output | 1 | Qualifies `llr_out` |
| llr_out | output | DEG*W | Extrinsic check-to-variable messages, edge k at [k*W +: W] |

## Verification
The bench builds the block with its defaults, W = 6 and DEG = 4. At that size the random stimulus can cover the whole 64-value message range, so every input code is reached, including the saturating -32 and zero. Four edges also mean every output excludes exactly one input, which lets the bench find an output that picked up its own edge. Directed vectors put the minimum at each edge position in turn, and bursts with gaps in the valid stream exercise the two-cycle alignment.

// File: rtl/cnp_pkg.sv
package cnp_pkg;
    // Default message width (two's complement) and check degree
    localparam int CNP_DEF_W   = 6;
    localparam int CNP_DEF_DEG = 4;
endpackage

// File: rtl/cnp_llr_to_sm.sv
module cnp_llr_to_sm #(
    parameter int W = 6
) (
    input  logic [W-1:0] llr,
    output logic         sgn,
    output logic [W-2:0] mag
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] neg_d;

    always_comb begin
        sgn   = llr[W-1];
        neg_d = -llr;
        if (llr == MOST_NEG) begin
            mag = '1;                       // saturate, R5
        end else if (llr[W-1]) begin
            mag = neg_d[W-2:0];
        end else begin
            mag = llr[W-2:0];
        end
    end
endmodule

// File: rtl/cnp_sm_to_llr.sv
module cnp_sm_to_llr #(
    parameter int W = 6
) (
    input  logic         sgn,
    input  logic [W-2:0] mag,
    output logic [W-1:0] llr
);
    logic [W-1:0] pos_d;

    always_comb begin
        pos_d = {1'b0, mag};
        if (mag == '0) begin
            llr = '0;                        // no negative zero, R6
        end else if (sgn) begin
            llr = -pos_d;
        end else begin
            llr = pos_d;
        end
    end
endmodule

// File: rtl/cnp_minsum_trellis.sv
module cnp_minsum_trellis #(
    parameter int DEG   = 4,
    parameter int MAG_W = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           valid_in,
    input  logic [DEG-1:0]                 sgn_in,
    input  logic [DEG-1:0][MAG_W-1:0]      mag_in,
    output logic                           valid_out,
    output logic [DEG-1:0]                 sgn_out,
    output logic [DEG-1:0][MAG_W-1:0]      mag_out
);
    localparam logic [MAG_W-1:0] MAG_TOP = '1;

    typedef struct packed {
        logic                      v1;
        logic [DEG-1:0]            s1;
        logic [DEG-1:0][MAG_W-1:0] m1;
        logic                      v2;
        logic [DEG-1:0]            s2;
        logic [DEG-1:0][MAG_W-1:0] m2;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [DEG:0]            fwd_s_d, bwd_s_d;
    logic [DEG:0][MAG_W-1:0] fwd_m_d, bwd_m_d;

    always_comb begin
        // forward chain: combination of edges 0..k-1 sits at index k
        fwd_s_d[0] = 1'b0;
        fwd_m_d[0] = MAG_TOP;
        for (int k = 0; k < DEG; k++) begin
            fwd_s_d[k+1] = fwd_s_d[k] ^ st_q.s1[k];
            fwd_m_d[k+1] = (st_q.m1[k] < fwd_m_d[k]) ? st_q.m1[k] : fwd_m_d[k];
        end
        // backward chain: combination of edges k..DEG-1 sits at index k
        bwd_s_d[DEG] = 1'b0;
        bwd_m_d[DEG] = MAG_TOP;
        for (int k = DEG - 1; k >= 0; k--) begin
            bwd_s_d[k] = bwd_s_d[k+1] ^ st_q.s1[k];
            bwd_m_d[k] = (st_q.m1[k] < bwd_m_d[k+1]) ? st_q.m1[k] : bwd_m_d[k+1];
        end

        st_d    = st_q;
        st_d.v1 = valid_in;
        st_d.s1 = sgn_in;
        st_d.m1 = mag_in;
        st_d.v2 = st_q.v1;
        for (int k = 0; k < DEG; k++) begin
            st_d.s2[k] = fwd_s_d[k] ^ bwd_s_d[k+1];
            st_d.m2[k] = (fwd_m_d[k] < bwd_m_d[k+1]) ? fwd_m_d[k] : bwd_m_d[k+1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_out = st_q.v2;
    assign sgn_out   = st_q.s2;
    assign mag_out   = st_q.m2;

    // Two-cycle alignment of the valid strobe
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out == $past(valid_in, 2));

    for (genvar k = 0; k < DEG; k++) begin : g_chk
        // Output sign equals parity of all captured signs except its own
        assert_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.v1 |=> (sgn_out[k] == ($past(^st_q.s1) ^ $past(st_q.s1[k]))));
        for (genvar j = 0; j < DEG; j++) begin : g_other
            if (j != k) begin : g_ne
                // Output magnitude never exceeds any other edge's magnitude
                assert_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    st_q.v1 |=> (mag_out[k] <= $past(st_q.m1[j])));
            end
        end
    end
endmodule

// File: rtl/cnp_trellis_top.sv
module cnp_trellis_top
    import cnp_pkg::*;
#(
    parameter int W   = CNP_DEF_W,
    parameter int DEG = CNP_DEF_DEG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_in,
    input  logic [DEG*W-1:0] llr_in,
    output logic             valid_out,
    output logic [DEG*W-1:0] llr_out
);
    localparam int MAG_W = W - 1;
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic [DEG-1:0]            in_sgn, out_sgn;
    logic [DEG-1:0][MAG_W-1:0] in_mag, out_mag;

    for (genvar e = 0; e < DEG; e++) begin : g_edge
        cnp_llr_to_sm #(.W(W)) u_in (
            .llr (llr_in[e*W +: W]),
            .sgn (in_sgn[e]),
            .mag (in_mag[e])
        );
        cnp_sm_to_llr #(.W(W)) u_out (
            .sgn (out_sgn[e]),
            .mag (out_mag[e]),
            .llr (llr_out[e*W +: W])
        );
        assert_no_most_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
            valid_out |-> (llr_out[e*W +: W] != MOST_NEG));
    end

    cnp_minsum_trellis #(.DEG(DEG), .MAG_W(MAG_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (valid_in),
        .sgn_in    (in_sgn),
        .mag_in    (in_mag),
        .valid_out (valid_out),
        .sgn_out   (out_sgn),
        .mag_out   (out_mag)
    );
endmodule

// File: tb/tb_cnp_trellis_top.sv
module tb_cnp_trellis_top;
    localparam int W   = 6;
    localparam int DEG = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             valid_in = 1'b0;
    logic [DEG*W-1:0] llr_in = '0;
    logic             valid_out;
    logic [DEG*W-1:0] llr_out;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 0;
    int    pin [2][DEG];
    bit    pv  [2];
    string ptag[2];

    always #10 clk = ~clk;   // 50 MHz

    cnp_trellis_top #(.W(W), .DEG(DEG)) dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
        .llr_in(llr_in), .valid_out(valid_out), .llr_out(llr_out)
    );

    function automatic int ref_out(input int a[DEG], input int k);
        bit s = 0;
        int m = 31;
        for (int j = 0; j < DEG; j++) begin
            if (j != k) begin
                int v = a[j];
                int mv = (v < 0) ? -v : v;
                if (mv > 31) mv = 31;
                s ^= (v < 0);
                if (mv < m) m = mv;
            end
        end
        if (m == 0) return 0;
        return s ? -m : m;
    endfunction

    task automatic step(input bit v, input int a[DEG], input string tag);
        @(negedge clk);
        n_chk++;
        if (valid_out !== pv[1]) begin
            n_err++;
            $display("FAIL R1 %s valid_out: got %0b expected %0b", ptag[1], valid_out, pv[1]);
        end
        if (pv[1]) begin
            for (int k = 0; k < DEG; k++) begin
                int e = ref_out(pin[1], k);
                int g = $signed(llr_out[k*W +: W]);
                n_chk++;
                if (g != e) begin
                    n_err++;
                    $display("FAIL %s %s edge %0d: got %0d expected %0d",
                             ((g < 0) != (e < 0)) ? "R3" : "R4", ptag[1], k, g, e);
                end
            end
        end
        pin[1] = pin[0]; pv[1] = pv[0]; ptag[1] = ptag[0];
        pin[0] = a;      pv[0] = v;     ptag[0] = tag;
        valid_in = v;
        for (int k = 0; k < DEG; k++) llr_in[k*W +: W] = W'(a[k]);
    endtask

    initial begin
        int z[DEG];
        z = '{0, 0, 0, 0};
        pv[0] = 0; pv[1] = 0; ptag[0] = ""; ptag[1] = "";
        pin[0] = z; pin[1] = z;
        void'($urandom(32'd2024));
        // reset state, R7
        repeat (3) begin
            @(negedge clk);
            n_chk++;
            if (valid_out !== 1'b0 || llr_out !== '0) begin
                n_err++;
                $display("FAIL R7 reset: got v=%0b out=%h expected v=0 out=0", valid_out, llr_out);
            end
        end
        rst_n = 1'b1;
        step(0, z, "R7");
        step(0, z, "R7");
        // directed cases
        step(1, '{5, 9, 12, 20}, "R4 positive");
        step(1, '{-5, 9, -12, 20}, "R3 mixed");
        step(1, '{-32, -32, -32, -32}, "R5 saturate");
        step(1, '{-32, 31, 31, 31}, "R5 sat-vs-max");
        step(0, z, "R1 gap");
        step(1, '{0, -7, -3, 11}, "R6 zero");
        step(1, '{-1, 0, 0, -1}, "R6 two zeros");
        step(1, '{3, -8, 13, -20}, "R8 packing");
        step(1, '{25, 2, 25, 25}, "R4 min edge1");
        step(1, '{25, 25, -2, 25}, "R4 min edge2");
        step(1, '{25, 25, 25, 1}, "R4 min edge3");
        step(0, z, "R1 gap");
        step(0, z, "R1 gap");
        // random, back-to-back and gapped, R2
        for (int i = 0; i < 3000; i++) begin
            int a[DEG];
            for (int k = 0; k < DEG; k++) a[k] = int'($urandom % 64) - 32;
            step(($urandom % 4) != 0, a, "R2 random");
        end
        step(0, z, "flush");
        step(0, z, "flush");
        step(0, z, "flush");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule